// File: doc/BRIEF.md
# Hypervisor-Aware Interrupt Pending Selector

This block decides which local interrupt a hart with hypervisor support should take next. Each cycle it looks at the pending and enable vectors, the delegation mask, the current privilege level, whether the hart runs a virtualized guest, and three global interrupt-enable bits: machine, supervisor, and the copy of the supervisor bit that belongs to the non-virtualized host supervisor. From these it picks one interrupt number.

Outside a guest, the candidates are the enabled pending bits with the three guest-supervisor bits removed. Each candidate is gated by the machine-level or supervisor-level global enable, depending on whether it is delegated. Inside a guest, any enabled host-level interrupt wins first when the host supervisor enable allows it, and a flag tells the trap logic to handle it at host-supervisor level. Otherwise the guest-supervisor bits move down one position onto the matching supervisor bits, and the same delegation rule applies to them. The lowest-numbered candidate wins. The result is registered once on the clock edge.

Top module: `hvIrqSelect`

## Requirements
- R1: The base pending set is `pendVec & enVec` with bits 2, 6 and 10 cleared (guest-supervisor software, timer and external). Outside a guest those three bits never produce a selection, and a pending bit whose enable bit is 0 is never chosen.
- R2: The machine gate is true when the privilege is below machine (`privLvl` is not 3) or when `privLvl` is 3 and `mIe` is 1. Privilege encoding: 0 is user, 1 is supervisor, 3 is machine.
- R3: The supervisor gate is true when `privLvl` is 0, or when `privLvl` is 1 and `sIe` is 1. The host gate follows the same rule using `hsSIe` in place of `sIe`.
- R4: A pending bit whose `delegMask` bit is 0 is a candidate only under the machine gate. A pending bit whose `delegMask` bit is 1 is a candidate only under the supervisor gate.
- R5: The lowest-numbered candidate bit is reported on `irqNum`.
- R6: When `virtOn` is 1, the host gate is true and the base pending set is non-zero, the lowest base pending bit is selected and `forceHs` is 1. Delegation and the machine and supervisor gates are ignored in this case.
- R7: When `virtOn` is 1 and R6 does not apply, the candidates come only from bits 2, 6 and 10 of `pendVec & enVec`, shifted down to bits 1, 5 and 9, under the rule of R4. `forceHs` is 0 in this case.
- R8: When no candidate exists, `irqValid` and `forceHs` are 0.
- R9: The outputs reflect the inputs sampled at the previous rising clock edge. A synchronous active-high `rst` clears `irqValid`, `irqNum` and `forceHs`.
- R10: While `virtOn` is 0, `forceHs` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pendVec | input | 64 | Interrupt pending vector |
| enVec | input | 64 | Interrupt enable vector |
| delegMask | input | 64 | Delegation mask; 1 routes the bit to supervisor level |
| privLvl | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| virtOn | input | 1 | Hart is running a virtualized guest |
| mIe | input | 1 | Machine global interrupt enable |
| sIe | input | 1 | Supervisor global interrupt enable (guest view while virtualized) |
| hsSIe | input | 1 | Host supervisor global interrupt enable |
| irqValid | output | 1 | An interrupt is selected |
| irqNum | output | 6 | Number of the selected interrupt |
| forceHs | output | 1 | Trap must be handled at host-supervisor level |

## Verification
The only state in this block is the output register. A wrong gate, a wrong mask or a wrong selection therefore shows at the ports one clock after the inputs that expose it. The directed scenarios are built so that each kind of fault changes a result:
- Each pattern has exactly one expected winner, so dropping a gate flips `irqValid` and mis-selecting changes `irqNum`.
- A wrong remap in guest mode moves `irqNum` by one.
- A host interrupt that fails to pre-empt clears `forceHs`.

Reset and the one-cycle latency are checked by sampling before and after each edge.

// File: rtl/hvIrqPkg.sv
package hvIrqPkg;
  typedef enum logic [1:0] {
    PRIV_USER  = 2'd0,
    PRIV_SUPER = 2'd1,
    PRIV_RSVD  = 2'd2,
    PRIV_MACH  = 2'd3
  } privE;

  // Strobes from control to datapath.
  typedef struct packed {
    logic mGate;
    logic sGate;
    logic hsGate;
    logic virt;
  } gateS;

  // Positions of the guest-supervisor interrupt bits.
  localparam int GuestSoftBit = 2;
  localparam int GuestTimeBit = 6;
  localparam int GuestExtBit  = 10;
endpackage

// File: rtl/hvIrqCtrl.sv
module hvIrqCtrl
  import hvIrqPkg::*;
(
  input  logic [1:0] privLvl,
  input  logic       virtOn,
  input  logic       mIe,
  input  logic       sIe,
  input  logic       hsSIe,
  output gateS       gates
);
  privE curPriv;
  logic belowMach;
  logic belowSuper;
  logic atSuper;

  always_comb begin
    curPriv    = privE'(privLvl);
    belowMach  = (curPriv != PRIV_MACH);
    belowSuper = (curPriv == PRIV_USER);
    atSuper    = (curPriv == PRIV_SUPER);

    gates.mGate  = belowMach  | ((curPriv == PRIV_MACH) & mIe);
    gates.sGate  = belowSuper | (atSuper & sIe);
    gates.hsGate = belowSuper | (atSuper & hsSIe);
    gates.virt   = virtOn;
  end
endmodule

// File: rtl/hvIrqPath.sv
module hvIrqPath
  import hvIrqPkg::*;
#(
  parameter int W = 64,
  localparam int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  pendVec,
  input  logic [W-1:0]  enVec,
  input  logic [W-1:0]  delegMask,
  input  gateS          gates,
  output logic          irqValid,
  output logic [IW-1:0] irqNum,
  output logic          forceHs
);
  localparam logic [W-1:0] One = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] GuestMask =
    (One << GuestSoftBit) | (One << GuestTimeBit) | (One << GuestExtBit);

  logic [W-1:0]  armed;
  logic [W-1:0]  basePend;
  logic [W-1:0]  guestPend;
  logic [W-1:0]  hostPend;
  logic [W-1:0]  workPend;
  logic [W-1:0]  cands;
  logic [W-1:0]  pickSrc;
  logic [W-1:0]  lowOne;
  logic [IW-1:0] pickIdx;
  logic          hostWins;

  always_comb begin
    armed     = pendVec & enVec;
    basePend  = armed & ~GuestMask;
    guestPend = (armed & GuestMask) >> 1;
    hostPend  = basePend & {W{gates.hsGate}};
    hostWins  = gates.virt & (|hostPend);
    workPend  = gates.virt ? guestPend : basePend;
    cands     = (workPend & ~delegMask & {W{gates.mGate}}) |
                (workPend &  delegMask & {W{gates.sGate}});
    pickSrc   = hostWins ? hostPend : cands;
    lowOne    = pickSrc & (~pickSrc + One);
  end

  // Encode the isolated lowest set bit: each index bit ORs the matching positions.
  genvar gb;
  generate
    for (gb = 0; gb < IW; gb++) begin : g_enc
      logic [W-1:0] selMask;
      always_comb begin
        for (int k = 0; k < W; k++) selMask[k] = ((k >> gb) & 1) == 1;
        pickIdx[gb] = |(lowOne & selMask);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      irqValid <= 1'b0;
      irqNum   <= '0;
      forceHs  <= 1'b0;
    end else begin
      irqValid <= |pickSrc;
      irqNum   <= pickIdx;
      forceHs  <= hostWins;
    end
  end
endmodule

// File: rtl/hvIrqSelect.sv
module hvIrqSelect
  import hvIrqPkg::*;
#(
  parameter int W = 64,
  localparam int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  pendVec,
  input  logic [W-1:0]  enVec,
  input  logic [W-1:0]  delegMask,
  input  logic [1:0]    privLvl,
  input  logic          virtOn,
  input  logic          mIe,
  input  logic          sIe,
  input  logic          hsSIe,
  output logic          irqValid,
  output logic [IW-1:0] irqNum,
  output logic          forceHs
);
  gateS gates;

  hvIrqCtrl ctrl (
    .privLvl (privLvl),
    .virtOn  (virtOn),
    .mIe     (mIe),
    .sIe     (sIe),
    .hsSIe   (hsSIe),
    .gates   (gates)
  );

  hvIrqPath #(.W(W)) path (
    .clk       (clk),
    .rst       (rst),
    .pendVec   (pendVec),
    .enVec     (enVec),
    .delegMask (delegMask),
    .gates     (gates),
    .irqValid  (irqValid),
    .irqNum    (irqNum),
    .forceHs   (forceHs)
  );
endmodule

// File: rtl/hvIrqSelectChk.sv
module hvIrqSelectChk #(
  parameter int W = 64,
  localparam int IW = $clog2(W)
) (
  input logic          clk,
  input logic          rst,
  input logic [W-1:0]  pendVec,
  input logic [W-1:0]  enVec,
  input logic [W-1:0]  delegMask,
  input logic [1:0]    privLvl,
  input logic          virtOn,
  input logic          mIe,
  input logic          sIe,
  input logic          hsSIe,
  input logic          irqValid,
  input logic [IW-1:0] irqNum,
  input logic          forceHs
);
  localparam logic [W-1:0] One = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] GMask = (One << 2) | (One << 6) | (One << 10);

  logic [W-1:0] pastArmed;
  logic [W-1:0] pastDeleg;
  logic         pastSGate;
  always_ff @(posedge clk) begin
    pastArmed <= pendVec & enVec;
    pastDeleg <= delegMask;
    pastSGate <= (privLvl == 2'd0) | ((privLvl == 2'd1) & sIe);
  end

  // R9: the first sample after reset shows cleared outputs
  p_reset_clear_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irqValid && !forceHs));

  // R10: forcing to host level needs guest mode in the sampled cycle
  p_force_virt_r10: assert property (@(posedge clk) disable iff (rst)
    forceHs |-> $past(virtOn));

  // R8: nothing armed means nothing selected
  p_empty_r8: assert property (@(posedge clk) disable iff (rst)
    (pastArmed == '0) |-> (!irqValid && !forceHs));

  // R2: machine level with mIe clear allows no selection outside a guest
  p_mgate_r2: assert property (@(posedge clk) disable iff (rst)
    $past(!virtOn && privLvl == 2'd3 && !mIe) |-> !irqValid);

  // R1, R5: outside a guest the winner is an armed bit and not a guest bit
  p_armed_r1: assert property (@(posedge clk) disable iff (rst)
    (irqValid && $past(!virtOn)) |->
      ((((pastArmed & ~GMask) >> irqNum) & One) != '0));

  // R4: with the supervisor gate closed, the winner is not delegated
  p_deleg_r4: assert property (@(posedge clk) disable iff (rst)
    (irqValid && !forceHs && !pastSGate) |-> (((pastDeleg >> irqNum) & One) == '0));

  // R6: a host interrupt in a guest with the host gate open is forced
  p_host_r6: assert property (@(posedge clk) disable iff (rst)
    $past(virtOn && (privLvl == 2'd0 || (privLvl == 2'd1 && hsSIe)) &&
          ((pendVec & enVec & ~GMask) != '0)) |-> (forceHs && irqValid));

  // R7: a guest selection that is not forced lands on 1, 5 or 9
  p_remap_r7: assert property (@(posedge clk) disable iff (rst)
    (irqValid && !forceHs && $past(virtOn)) |->
      (irqNum == IW'(1) || irqNum == IW'(5) || irqNum == IW'(9)));
endmodule

bind hvIrqSelect hvIrqSelectChk #(.W(W)) chk (
  .clk(clk), .rst(rst), .pendVec(pendVec), .enVec(enVec), .delegMask(delegMask),
  .privLvl(privLvl), .virtOn(virtOn), .mIe(mIe), .sIe(sIe), .hsSIe(hsSIe),
  .irqValid(irqValid), .irqNum(irqNum), .forceHs(forceHs)
);

// File: tb/hvIrqSelect_test.sv
module hvIrqSelect_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] pendVec = '0;
  logic [63:0] enVec = '0;
  logic [63:0] delegMask = '0;
  logic [1:0]  privLvl = 2'd0;
  logic        virtOn = 1'b0;
  logic        mIe = 1'b0;
  logic        sIe = 1'b0;
  logic        hsSIe = 1'b0;
  logic        irqValid;
  logic [5:0]  irqNum;
  logic        forceHs;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hvIrqSelect uut (
    .clk(clk), .rst(rst), .pendVec(pendVec), .enVec(enVec), .delegMask(delegMask),
    .privLvl(privLvl), .virtOn(virtOn), .mIe(mIe), .sIe(sIe), .hsSIe(hsSIe),
    .irqValid(irqValid), .irqNum(irqNum), .forceHs(forceHs)
  );

  function automatic logic [63:0] bt(int n);
    return 64'd1 << n;
  endfunction

  task automatic expect3(string req, bit eV, int eN, bit eF);
    bit bad;
    compared++;
    bad = (irqValid !== eV) || (forceHs !== eF) || (eV && irqNum !== 6'(eN));
    if (bad) begin
      mismatched++;
      $display("FAIL %s: got valid=%0b num=%0d force=%0b, expected valid=%0b num=%0d force=%0b",
               req, irqValid, irqNum, forceHs, eV, eN, eF);
    end
  endtask

  // Drive at a falling edge, sample at the next falling edge (one rising edge between).
  task automatic apply(logic [63:0] p, logic [63:0] e, logic [63:0] d,
                       logic [1:0] pr, bit v, bit m, bit s, bit h);
    @(negedge clk);
    pendVec = p; enVec = e; delegMask = d; privLvl = pr;
    virtOn = v; mIe = m; sIe = s; hsSIe = h;
    @(negedge clk);
  endtask

  task automatic t_reset();
    pendVec = bt(7); enVec = '1;
    repeat (3) @(negedge clk);
    expect3("R9 reset", 0, 0, 0);
    rst = 1'b0;
    @(negedge clk);
    expect3("R9 after reset", 1, 7, 0);
  endtask

  task automatic t_guestBitsMasked();
    apply(bt(2) | bt(6) | bt(10), '1, '0, 2'd0, 0, 0, 0, 0);
    expect3("R1 guest bits ignored", 0, 0, 0);
    apply(bt(6) | bt(7), '1, '0, 2'd0, 0, 0, 0, 0);
    expect3("R1 guest bit skipped", 1, 7, 0);
    apply(bt(9), ~bt(9), '0, 2'd0, 0, 0, 0, 0);
    expect3("R1 enable off", 0, 0, 0);
  endtask

  task automatic t_machGate();
    apply(bt(7), '1, '0, 2'd3, 0, 0, 1, 1);
    expect3("R2 machine mIe=0", 0, 0, 0);
    apply(bt(7), '1, '0, 2'd3, 0, 1, 0, 0);
    expect3("R2 machine mIe=1", 1, 7, 0);
    apply(bt(7), '1, '0, 2'd1, 0, 0, 0, 0);
    expect3("R2 below machine", 1, 7, 0);
  endtask

  task automatic t_superGate();
    apply(bt(5), '1, bt(5), 2'd1, 0, 1, 0, 1);
    expect3("R3 super sIe=0", 0, 0, 0);
    apply(bt(5), '1, bt(5), 2'd1, 0, 0, 1, 0);
    expect3("R3 super sIe=1", 1, 5, 0);
    apply(bt(5), '1, bt(5), 2'd3, 0, 1, 1, 1);
    expect3("R3 machine above super", 0, 0, 0);
    apply(bt(5), '1, bt(5), 2'd0, 0, 0, 0, 0);
    expect3("R3 user below super", 1, 5, 0);
  endtask

  task automatic t_deleg();
    apply(bt(5) | bt(9), '1, bt(5), 2'd1, 0, 0, 0, 0);
    expect3("R4 only non-delegated", 1, 9, 0);
    apply(bt(5) | bt(9), '1, bt(5), 2'd3, 0, 1, 1, 0);
    expect3("R4 only machine-routed", 1, 9, 0);
  endtask

  task automatic t_lowest();
    apply(bt(3) | bt(11) | bt(40) | bt(63), '1, '0, 2'd0, 0, 0, 0, 0);
    expect3("R5 lowest of four", 1, 3, 0);
    apply(bt(63), '1, '0, 2'd0, 0, 0, 0, 0);
    expect3("R5 top bit", 1, 63, 0);
    @(negedge clk);
    pendVec = bt(0);
    #1;
    expect3("R9 held before edge", 1, 63, 0);
    @(negedge clk);
    expect3("R5 bit zero", 1, 0, 0);
  endtask

  task automatic t_hostWins();
    apply(bt(9) | bt(2), '1, '0, 2'd0, 1, 0, 0, 0);
    expect3("R6 host pre-empts", 1, 9, 1);
    apply(bt(9) | bt(2), '1, bt(1) | bt(9), 2'd1, 1, 0, 1, 0);
    expect3("R7 host gate closed", 1, 1, 0);
    apply(bt(13) | bt(3), '1, bt(3) | bt(13), 2'd1, 1, 0, 0, 1);
    expect3("R6 ignores delegation", 1, 3, 1);
  endtask

  task automatic t_guestRemap();
    apply(bt(6) | bt(10), '1, bt(5) | bt(9), 2'd0, 1, 0, 0, 0);
    expect3("R7 timer remap", 1, 5, 0);
    apply(bt(10), '1, '0, 2'd0, 1, 0, 0, 0);
    expect3("R7 external remap", 1, 9, 0);
    apply(bt(10), '1, bt(9), 2'd1, 1, 1, 0, 0);
    expect3("R7 delegated gated", 0, 0, 0);
  endtask

  task automatic t_empty();
    apply('0, '1, '0, 2'd0, 1, 1, 1, 1);
    expect3("R8 nothing pending", 0, 0, 0);
  endtask

  task automatic t_noForce();
    apply(bt(9), '1, '0, 2'd0, 0, 1, 1, 1);
    expect3("R10 not in guest", 1, 9, 0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    expect3("R9 reset mid-run", 0, 0, 0);
    rst = 1'b0;
  endtask

  initial begin
    t_reset();
    t_guestBitsMasked();
    t_machGate();
    t_superGate();
    t_deleg();
    t_lowest();
    t_hostWins();
    t_guestRemap();
    t_empty();
    t_noForce();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule